// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This block keeps the 13-bit program counter of a small instruction-fetch engine and the return addresses that go with it. Each clock cycle an external decoder raises at most a few command strobes: step to the next word, load the low counter byte from the data path, jump, call, return, or take the interrupt vector. The upper counter bits are never written directly. They come from a separate 5-bit page latch that software loads ahead of a computed branch. A write to the low byte takes all five page bits. A jump or call takes only the top two, because the opcode already supplies eleven address bits.

Return addresses sit in an 8-entry ring with no full or empty indication. A ninth call overwrites the oldest entry. Extra returns keep walking backwards around the ring and yield whatever value is stored there. The fetch address is the counter folded onto the implemented program memory, so a counter above the memory size aliases into it.

Top module: `paged_pc_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, the page latch, the ring pointer and every ring entry are cleared to zero.
- R2: When only `inc_i` is raised, the counter becomes its previous value plus one, modulo 8192 (0x1FFF is followed by 0x0000).
- R3: A low-byte write (`lowwr_i`) loads the counter with page-latch bits 4..0 as counter bits 12..8 and `lowwr_data_i` as bits 7..0.
- R4: A jump (`jump_i`) loads counter bits 10..0 from `opcode_i` bits 10..0 and counter bits 12..11 from page-latch bits 4..3.
- R5: A call (`call_i`) goes to the same target as a jump and pushes the previous counter plus one onto the ring.
- R6: An interrupt (`irq_i`) loads the counter with 0x0004 and pushes the previous counter unchanged.
- R7: A return (`ret_i`) loads the counter with the most recently pushed entry that has not been popped, so nested calls unwind last-in first-out.
- R8: The ring holds 8 entries with no overflow or underflow indication. Push number 9 overwrites entry 1. Each pop moves the pointer back one slot modulo 8 and returns the stale contents found there.
- R9: `page_wr_i` loads the page latch from `page_data_i` at the clock edge. A command in the same cycle uses the old latch value. Pushes and pops never change the latch.
- R10: Strobes resolve by priority, highest first: `irq_i`, `ret_i`, `call_i`, `jump_i`, `lowwr_i`, `inc_i`. With no strobe the counter holds its value.
- R11: `fetch_addr_o` equals the counter modulo the implemented memory size (default 512 words, so counter bits 8..0).
- R12: `pcl_o` always equals counter bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_i | input | 1 | Step to the next sequential word |
| lowwr_i | input | 1 | Load the low counter byte from the data path |
| lowwr_data_i | input | 8 | Byte for the low-byte write |
| jump_i | input | 1 | Jump to the opcode target |
| call_i | input | 1 | Call the opcode target and push the return address |
| ret_i | input | 1 | Return: pop the ring into the counter |
| irq_i | input | 1 | Take the interrupt vector and push the current counter |
| opcode_i | input | 11 | Target field of the jump or call opcode |
| page_wr_i | input | 1 | Write strobe for the page latch |
| page_data_i | input | 5 | New page latch value |
| pc_o | output | 13 | Full program counter |
| pcl_o | output | 8 | Low counter byte for readback |
| fetch_addr_o | output | 9 | Counter folded onto the implemented memory |

## Verification
The properties assume the decoder may raise any mix of strobes. Each property therefore fires only when its own command wins the priority, and the bench sweeps all 64 strobe combinations so that the losing strobes are shown to have no effect. The properties also assume that the page latch a command sees is the value held before that edge. The bench writes the latch in the same cycle as jumps, calls and low-byte writes to exercise that timing. The ring checks assume nothing about balance: the bench deliberately calls more than eight deep and returns more often than it called.

// File: rtl/pcs_pkg.sv
// Shared types for the paged program counter.
// Assumes: only one command is acted on per cycle (priority resolved upstream of the datapath).
package pcs_pkg;
    typedef enum logic [2:0] {
        CMD_HOLD,
        CMD_INC,
        CMD_LOWWR,
        CMD_JUMP,
        CMD_CALL,
        CMD_RET,
        CMD_IRQ
    } pc_cmd_e;
endpackage

// File: rtl/pcs_cmd_decode.sv
// Resolves the raw command strobes into one command by fixed priority.
// Assumes: strobes may overlap freely; lower-priority strobes are dropped.
module pcs_cmd_decode
    import pcs_pkg::*;
(
    input  logic    inc_i,
    input  logic    lowwr_i,
    input  logic    jump_i,
    input  logic    call_i,
    input  logic    ret_i,
    input  logic    irq_i,
    output pc_cmd_e cmd_o
);
    // Priority chain: interrupt, return, call, jump, low write, increment.
    always_comb begin
        if (irq_i)        cmd_o = CMD_IRQ;
        else if (ret_i)   cmd_o = CMD_RET;
        else if (call_i)  cmd_o = CMD_CALL;
        else if (jump_i)  cmd_o = CMD_JUMP;
        else if (lowwr_i) cmd_o = CMD_LOWWR;
        else if (inc_i)   cmd_o = CMD_INC;
        else              cmd_o = CMD_HOLD;
    end
endmodule

// File: rtl/pcs_next_pc.sv
// Computes the next counter value and the ring push/pop requests for one command.
// Assumes: PAGE_W == PC_W - LOW_W and JMP_W < PC_W; the page latch is already registered.
module pcs_next_pc
    import pcs_pkg::*;
#(
    parameter int PC_W    = 13,
    parameter int LOW_W   = 8,
    parameter int JMP_W   = 11,
    parameter int INT_VEC = 4,
    localparam int PAGE_W = PC_W - LOW_W,
    localparam int HI_W   = PC_W - JMP_W
) (
    input  pc_cmd_e           cmd_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [LOW_W-1:0]  low_data_i,
    input  logic [JMP_W-1:0]  opcode_i,
    input  logic [PC_W-1:0]   pop_data_i,
    output logic [PC_W-1:0]   pc_nxt_o,
    output logic              push_o,
    output logic              pop_o,
    output logic [PC_W-1:0]   push_data_o
);
    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] jmp_addr;
    logic [PC_W-1:0] low_addr;

    // Candidate targets for each load path.
    always_comb begin
        seq_addr = pc_i + PC_W'(1);
        jmp_addr = {page_i[PAGE_W-1 -: HI_W], opcode_i};
        low_addr = {page_i, low_data_i};
    end

    // Select the next counter and ring action for the winning command.
    always_comb begin
        pc_nxt_o    = pc_i;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_data_o = seq_addr;
        unique case (cmd_i)
            CMD_INC:   pc_nxt_o = seq_addr;
            CMD_LOWWR: pc_nxt_o = low_addr;
            CMD_JUMP:  pc_nxt_o = jmp_addr;
            CMD_CALL: begin
                pc_nxt_o = jmp_addr;
                push_o   = 1'b1;
            end
            CMD_RET: begin
                pc_nxt_o = pop_data_i;
                pop_o    = 1'b1;
            end
            CMD_IRQ: begin
                pc_nxt_o    = PC_W'(INT_VEC);
                push_o      = 1'b1;
                push_data_o = pc_i;
            end
            default:   pc_nxt_o = pc_i;
        endcase
    end
endmodule

// File: rtl/pcs_ret_stack.sv
// Circular return-address ring with no full or empty tracking.
// Assumes: push and pop are never requested together; DEPTH is a power of two.
module pcs_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [W-1:0]     push_data_i,
    output logic [W-1:0]     top_o,
    output logic [PTR_W-1:0] ptr_o
);
    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] top_idx;

    // Index of the newest entry, one slot behind the free pointer.
    always_comb top_idx = ptr_q - PTR_W'(1);

    // Pointer moves forward on push and back on pop, wrapping silently.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (push_i) ptr_q <= ptr_q + PTR_W'(1);
        else if (pop_i)  ptr_q <= top_idx;
    end

    // One register per slot; a push overwrites whatever the slot held.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                 slot_q[g] <= '0;
            else if (push_i && ptr_q == PTR_W'(g))      slot_q[g] <= push_data_i;
        end
    end

    assign top_o = slot_q[top_idx];
    assign ptr_o = ptr_q;
endmodule

// File: rtl/paged_pc_stack.sv
// Program counter with a separately written page latch and a circular return ring.
// Assumes: MEM_WORDS is a power of two not larger than 2**PC_W.
module paged_pc_stack
    import pcs_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int LOW_W     = 8,
    parameter int JMP_W     = 11,
    parameter int DEPTH     = 8,
    parameter int MEM_WORDS = 512,
    parameter int INT_VEC   = 4,
    localparam int PAGE_W   = PC_W - LOW_W,
    localparam int ADDR_W   = $clog2(MEM_WORDS),
    localparam int PTR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              lowwr_i,
    input  logic [LOW_W-1:0]  lowwr_data_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              irq_i,
    input  logic [JMP_W-1:0]  opcode_i,
    input  logic              page_wr_i,
    input  logic [PAGE_W-1:0] page_data_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [LOW_W-1:0]  pcl_o,
    output logic [ADDR_W-1:0] fetch_addr_o
);
    pc_cmd_e           cmd;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   pc_nxt;
    logic [PAGE_W-1:0] page_q;
    logic              push;
    logic              pop;
    logic [PC_W-1:0]   push_data;
    logic [PC_W-1:0]   top_data;
    logic [PTR_W-1:0]  ring_ptr;

    pcs_cmd_decode u_dec (
        .inc_i   (inc_i),
        .lowwr_i (lowwr_i),
        .jump_i  (jump_i),
        .call_i  (call_i),
        .ret_i   (ret_i),
        .irq_i   (irq_i),
        .cmd_o   (cmd)
    );

    pcs_next_pc #(
        .PC_W    (PC_W),
        .LOW_W   (LOW_W),
        .JMP_W   (JMP_W),
        .INT_VEC (INT_VEC)
    ) u_next (
        .cmd_i       (cmd),
        .pc_i        (pc_q),
        .page_i      (page_q),
        .low_data_i  (lowwr_data_i),
        .opcode_i    (opcode_i),
        .pop_data_i  (top_data),
        .pc_nxt_o    (pc_nxt),
        .push_o      (push),
        .pop_o       (pop),
        .push_data_o (push_data)
    );

    pcs_ret_stack #(
        .DEPTH (DEPTH),
        .W     (PC_W)
    ) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .top_o       (top_data),
        .ptr_o       (ring_ptr)
    );

    // Page latch: written only by its own strobe, never by ring traffic.
    always_ff @(posedge clk) begin
        if (!rst_n)         page_q <= '0;
        else if (page_wr_i) page_q <= page_data_i;
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    assign pc_o         = pc_q;
    assign pcl_o        = pc_q[LOW_W-1:0];
    assign fetch_addr_o = pc_q[ADDR_W-1:0];
endmodule

// File: rtl/paged_pc_stack_chk.sv
// Temporal checks on the paged program counter, bound into the top module.
// Assumes: the page latch and ring pointer are visible through the bind connection.
module paged_pc_stack_chk #(
    parameter int PC_W   = 13,
    parameter int LOW_W  = 8,
    parameter int JMP_W  = 11,
    parameter int PTR_W  = 3,
    localparam int PAGE_W = PC_W - LOW_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inc_i,
    input logic              lowwr_i,
    input logic [LOW_W-1:0]  lowwr_data_i,
    input logic              jump_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              irq_i,
    input logic [JMP_W-1:0]  opcode_i,
    input logic              page_wr_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [PAGE_W-1:0] page_q,
    input logic [PTR_W-1:0]  ring_ptr
);
    logic win_inc, win_low, win_jump, win_call, win_push, win_pop;

    // Which command takes effect this cycle, derived from the strobe priority.
    always_comb begin
        win_call = call_i & ~irq_i & ~ret_i;
        win_jump = jump_i & ~irq_i & ~ret_i & ~call_i;
        win_low  = lowwr_i & ~irq_i & ~ret_i & ~call_i & ~jump_i;
        win_inc  = inc_i & ~irq_i & ~ret_i & ~call_i & ~jump_i & ~lowwr_i;
        win_push = irq_i | win_call;
        win_pop  = ret_i & ~irq_i;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pc_o == '0 && page_q == '0 && ring_ptr == '0));

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_inc |=> pc_o == $past(pc_o) + PC_W'(1));

    // R3
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_low |=> pc_o == {$past(page_q), $past(lowwr_data_i)});

    // R4
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_jump | win_call) |=> pc_o == {$past(page_q[PAGE_W-1 -: PC_W-JMP_W]), $past(opcode_i)});

    // R6
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> pc_o == PC_W'(4));

    // R8
    ring_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_push |=> ring_ptr == $past(ring_ptr) + PTR_W'(1));

    // R8
    ring_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_pop |=> ring_ptr == $past(ring_ptr) - PTR_W'(1));

    // R9
    page_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!page_wr_i && (win_push || win_pop)) |=> $stable(page_q));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_i | lowwr_i | jump_i | call_i | ret_i | irq_i) |=> $stable(pc_o));
endmodule

bind paged_pc_stack paged_pc_stack_chk #(
    .PC_W  (PC_W),
    .LOW_W (LOW_W),
    .JMP_W (JMP_W),
    .PTR_W (PTR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inc_i        (inc_i),
    .lowwr_i      (lowwr_i),
    .lowwr_data_i (lowwr_data_i),
    .jump_i       (jump_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .irq_i        (irq_i),
    .opcode_i     (opcode_i),
    .page_wr_i    (page_wr_i),
    .pc_o         (pc_o),
    .page_q       (page_q),
    .ring_ptr     (ring_ptr)
);

// File: tb/paged_pc_stack_tb.sv
module paged_pc_stack_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_i = 0, lowwr_i = 0, jump_i = 0, call_i = 0, ret_i = 0, irq_i = 0;
    logic [7:0]  lowwr_data_i = '0;
    logic [10:0] opcode_i = '0;
    logic        page_wr_i = 0;
    logic [4:0]  page_data_i = '0;
    logic [12:0] pc_o;
    logic [7:0]  pcl_o;
    logic [8:0]  fetch_addr_o;

    int total = 0;
    int bad = 0;

    // Reference state, derived from the requirements.
    logic [12:0] m_pc = '0;
    logic [4:0]  m_page = '0;
    logic [12:0] m_ring [8];
    int          m_ptr = 0;

    always #10 clk = ~clk;

    paged_pc_stack u_dut (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .lowwr_i(lowwr_i),
        .lowwr_data_i(lowwr_data_i), .jump_i(jump_i), .call_i(call_i),
        .ret_i(ret_i), .irq_i(irq_i), .opcode_i(opcode_i),
        .page_wr_i(page_wr_i), .page_data_i(page_data_i),
        .pc_o(pc_o), .pcl_o(pcl_o), .fetch_addr_o(fetch_addr_o)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        chk(tag, int'(pc_o), int'(m_pc));
        chk("R12", int'(pcl_o), int'(m_pc[7:0]));
        chk("R11", int'(fetch_addr_o), int'(m_pc) % 512);
    endtask

    // Drive one cycle of strobes at the falling edge, update the model, check after the edge.
    task automatic cyc(bit inc, bit lw, bit [7:0] lwd, bit jmp, bit cal, bit ret,
                       bit irq, bit [10:0] op, bit pw, bit [4:0] pd, string tag_in);
        string tag;
        logic [12:0] nxt;
        inc_i = inc; lowwr_i = lw; lowwr_data_i = lwd; jump_i = jmp; call_i = cal;
        ret_i = ret; irq_i = irq; opcode_i = op; page_wr_i = pw; page_data_i = pd;
        nxt = m_pc;
        if (irq) begin
            tag = "R6"; m_ring[m_ptr] = m_pc; m_ptr = (m_ptr + 1) % 8; nxt = 13'h0004;
        end else if (ret) begin
            tag = "R7"; m_ptr = (m_ptr + 7) % 8; nxt = m_ring[m_ptr];
        end else if (cal) begin
            tag = "R5"; m_ring[m_ptr] = m_pc + 13'd1; m_ptr = (m_ptr + 1) % 8;
            nxt = {m_page[4:3], op};
        end else if (jmp) begin
            tag = "R4"; nxt = {m_page[4:3], op};
        end else if (lw) begin
            tag = "R3"; nxt = {m_page, lwd};
        end else if (inc) begin
            tag = "R2"; nxt = m_pc + 13'd1;
        end else begin
            tag = "R10";
        end
        if (pw) m_page = pd;
        m_pc = nxt;
        if (tag_in != "") tag = tag_in;
        @(posedge clk);
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic idle();
        cyc(0, 0, 8'h0, 0, 0, 0, 0, 11'h0, 0, 5'h0, "");
    endtask

    task automatic set_page(bit [4:0] p);
        cyc(0, 0, 8'h0, 0, 0, 0, 0, 11'h0, 1, p, "R9");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_ring[i] = '0;
        // R1: reset with garbage on the inputs
        inc_i = 1; call_i = 1; page_wr_i = 1; page_data_i = 5'h1F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_outputs("R1");
        rst_n = 1'b1;
        inc_i = 0; call_i = 0; page_wr_i = 0;
        idle();
        // R1: page latch cleared, ring entries cleared
        cyc(0, 1, 8'h5A, 0, 0, 0, 0, 11'h0, 0, 5'h0, "R1");
        cyc(0, 0, 8'h0, 0, 0, 1, 0, 11'h0, 0, 5'h0, "R1");

        // R2: full sweep of increments, including the wrap from 0x1FFF
        cyc(0, 1, 8'h00, 0, 0, 0, 0, 11'h0, 0, 5'h0, "R3");
        for (int i = 0; i < 8193; i++) cyc(1, 0, 8'h0, 0, 0, 0, 0, 11'h0, 0, 5'h0, "R2");

        // R3: every page with every low byte
        for (int p = 0; p < 32; p++) begin
            set_page(5'(p));
            for (int d = 0; d < 256; d++)
                cyc(0, 1, 8'(d), 0, 0, 0, 0, 11'h0, 0, 5'h0, "R3");
        end

        // R4: every opcode field under each value of the two page bits used
        for (int h = 0; h < 4; h++) begin
            set_page(5'({h[1:0], 3'b101}));
            for (int o = 0; o < 2048; o++)
                cyc(0, 0, 8'h0, 1, 0, 0, 0, 11'(o), 0, 5'h0, "R4");
        end

        // R9: page written in the same cycle as a jump or low write; old latch is used
        set_page(5'h00);
        cyc(0, 0, 8'h0, 1, 0, 0, 0, 11'h123, 1, 5'h18, "R9");
        cyc(0, 0, 8'h0, 1, 0, 0, 0, 11'h123, 0, 5'h0, "R9");
        cyc(0, 1, 8'h77, 0, 0, 0, 0, 11'h0, 1, 5'h03, "R9");
        cyc(0, 1, 8'h77, 0, 0, 0, 0, 11'h0, 0, 5'h0, "R9");

        // R5/R7: nested calls unwind in reverse order
        set_page(5'h08);
        cyc(0, 0, 8'h0, 1, 0, 0, 0, 11'h010, 0, 5'h0, "R4");
        cyc(0, 0, 8'h0, 0, 1, 0, 0, 11'h200, 0, 5'h0, "R5");
        cyc(1, 0, 8'h0, 0, 0, 0, 0, 11'h0, 0, 5'h0, "R2");
        cyc(0, 0, 8'h0, 0, 1, 0, 0, 11'h300, 1, 5'h10, "R5");
        cyc(0, 0, 8'h0, 0, 1, 0, 0, 11'h400, 0, 5'h0, "R5");
        cyc(0, 0, 8'h0, 0, 0, 1, 0, 11'h0, 0, 5'h0, "R7");
        cyc(0, 0, 8'h0, 0, 0, 1, 0, 11'h0, 0, 5'h0, "R7");
        cyc(0, 0, 8'h0, 0, 0, 1, 0, 11'h0, 0, 5'h0, "R7");
        // R9: latch still holds the value written before the pops
        cyc(0, 1, 8'h00, 0, 0, 0, 0, 11'h0, 0, 5'h0, "R9");

        // R6: interrupt from a nonzero counter, then return to it
        cyc(0, 0, 8'h0, 1, 0, 0, 0, 11'h555, 0, 5'h0, "R4");
        cyc(0, 0, 8'h0, 0, 0, 0, 1, 11'h0, 0, 5'h0, "R6");
        cyc(1, 0, 8'h0, 0, 0, 0, 0, 11'h0, 0, 5'h0, "R2");
        cyc(0, 0, 8'h0, 0, 0, 1, 0, 11'h0, 0, 5'h0, "R6");

        // R8: ten pushes then thirteen pops walk the ring past empty
        for (int k = 0; k < 10; k++)
            cyc(0, 0, 8'h0, 0, 1, 0, 0, 11'(k * 37 + 5), 0, 5'h0, "R8");
        for (int k = 0; k < 13; k++)
            cyc(0, 0, 8'h0, 0, 0, 1, 0, 11'h0, 0, 5'h0, "R8");

        // R10: all strobe combinations, each from a fresh counter value
        for (int c = 0; c < 64; c++) begin
            cyc(0, 1, 8'(c * 3), 0, 0, 0, 0, 11'h0, 0, 5'h0, "R3");
            cyc(c[0], c[1], 8'hC3, c[2], c[3], c[4], c[5], 11'(c * 29 + 1), 0, 5'h0, "R10");
        end
        repeat (3) idle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule